// File: doc/BRIEF.md
# MSI Event Queue Writer

This block turns incoming message-signalled interrupts into entries in circular queues that live in host memory. Every queue has its own base address, its own tail pointer that only the block advances, its own head pointer that software moves through a small register port, and its own level interrupt line. When an MSI arrives, a vector-to-queue table picks the target queue. The block then writes one 32-bit entry to that queue's next free slot over a request/acknowledge memory port. It moves the tail only after the memory acknowledges the write. The interrupt line follows from the moved tail.

Software consumes entries by reading them from memory and then writing the new head. Writing head equal to tail clears the queue's interrupt. Writing the table at run time moves a vector to another queue, and so to another CPU. When the target queue has no free slot, the block holds the incoming MSI with backpressure and writes nothing until software frees a slot.

Top module: `msi_evq_writer`

## Requirements
- R1: After reset every head and tail is 0, no interrupt is asserted, mem_req is low, msi_ready is high, and vector v is routed to queue v modulo NUM_Q.
- R2: The word written for an MSI carries msi_data in bits 15:0 and zero in bits 31:16.
- R3: The entry address is the target queue's base register plus 4 times that queue's tail index.
- R4: The tail of a queue advances by one only on the clock edge where mem_ack is sampled high for that queue's write, and it wraps from 63 to 0.
- R5: At most one memory write is outstanding. The block accepts an MSI on an edge with msi_valid and msi_ready both high, raises mem_req in the next cycle, and holds mem_req, mem_addr and mem_wdata stable until mem_ack. msi_ready is low while mem_req is high. Accepted MSIs are written in order of acceptance.
- R6: While (tail+1) mod 64 equals head for the queue that msi_vec maps to, msi_ready is low and no write is issued. A head write that frees a slot lets the held MSI proceed.
- R7: irq[q] is high exactly while head[q] differs from tail[q]. It rises in the cycle after the acknowledged write, and it falls after a head write makes head equal to tail.
- R8: A register write with reg_sel=2 sets the queue of vector reg_idx to reg_wdata[1:0]. It applies to MSIs accepted on later edges. MSIs accepted on the same edge use the old mapping.
- R9: A register write with reg_sel=0 sets head[reg_idx] to reg_wdata[5:0]. A write with reg_sel=1 sets base[reg_idx] to reg_wdata. A write with reg_sel=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_valid | input | 1 | Incoming MSI present |
| msi_ready | output | 1 | Block accepts the MSI on this edge |
| msi_vec | input | 6 | MSI vector number |
| msi_data | input | 16 | MSI data payload |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register kind: 0 head, 1 base, 2 vector map |
| reg_idx | input | 6 | Queue index (head, base) or vector index (map) |
| reg_wdata | input | 32 | Register write value |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry word |
| mem_ack | input | 1 | Memory write completed |
| irq | output | 4 | Per-queue interrupt level |

## Verification
The assertions check on every cycle that a pending request holds its address and data until acknowledged. They also check that no second MSI is accepted while a write is outstanding, that the upper half of each entry is zero, and that each interrupt line rises only just after an acknowledged write and falls only just after a head write. Only the bench scenarios can show the rest: that entry addresses follow the per-queue base and tail, including the wrap from slot 63 to 0, that a full queue holds its MSI until software frees a slot, and that remapped vectors land in their new queue in acceptance order.

// File: rtl/msi_evq_pkg.sv
package msi_evq_pkg;

    localparam int ENTRY_W   = 32;
    localparam int PAYLOAD_W = 16;

    // register port selector encoding
    typedef enum logic [1:0] {
        RSEL_HEAD = 2'd0,
        RSEL_BASE = 2'd1,
        RSEL_MAP  = 2'd2,
        RSEL_NONE = 2'd3
    } rsel_e;

    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_BUSY = 1'b1
    } wstate_e;

endpackage

// File: rtl/msi_evq_map.sv
module msi_evq_map #(
    parameter int NUM_VEC = 64,
    parameter int NUM_Q   = 4,
    localparam int VW = $clog2(NUM_VEC),
    localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [VW-1:0] wr_vec,
    input  logic [QW-1:0] wr_q,
    input  logic [VW-1:0] rd_vec,
    output logic [QW-1:0] rd_q
);

    typedef struct packed {
        logic [NUM_VEC-1:0][QW-1:0] tbl;
    } map_st_t;

    map_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.tbl[wr_vec] = wr_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int v = 0; v < NUM_VEC; v++) begin
                st_q.tbl[v] <= QW'(v % NUM_Q);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_q = st_q.tbl[rd_vec];

endmodule

// File: rtl/msi_evq_qstate.sv
module msi_evq_qstate
    import msi_evq_pkg::*;
#(
    parameter int NUM_Q       = 4,
    parameter int QUEUE_DEPTH = 64,
    parameter int ADDR_W      = 32,
    localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int PW = $clog2(QUEUE_DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [1:0]                  reg_sel,
    input  logic [QW-1:0]               reg_idx,
    input  logic [ADDR_W-1:0]           reg_wdata,
    input  logic                        adv_en,
    input  logic [QW-1:0]               adv_q,
    output logic [NUM_Q-1:0][PW-1:0]    tail_o,
    output logic [NUM_Q-1:0][ADDR_W-1:0] base_o,
    output logic [NUM_Q-1:0]            full_o,
    output logic [NUM_Q-1:0]            irq_o
);

    typedef struct packed {
        logic [NUM_Q-1:0][PW-1:0]     tail;
        logic [NUM_Q-1:0][PW-1:0]     head;
        logic [NUM_Q-1:0][ADDR_W-1:0] base;
    } q_st_t;

    q_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // tail: owned by the block, power-of-two depth wraps naturally
        if (adv_en && (int'(adv_q) < NUM_Q)) begin
            st_d.tail[adv_q] = st_q.tail[adv_q] + PW'(1);
        end
        if (reg_we && (int'(reg_idx) < NUM_Q)) begin
            case (rsel_e'(reg_sel))
                RSEL_HEAD: st_d.head[reg_idx] = reg_wdata[PW-1:0];
                RSEL_BASE: st_d.base[reg_idx] = reg_wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
        logic [PW-1:0] tail_nxt;
        assign tail_nxt  = st_q.tail[g] + PW'(1);
        assign full_o[g] = (tail_nxt == st_q.head[g]);
        assign irq_o[g]  = (st_q.head[g] != st_q.tail[g]);
    end

    assign tail_o = st_q.tail;
    assign base_o = st_q.base;

endmodule

// File: rtl/msi_evq_wr.sv
module msi_evq_wr
    import msi_evq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PW     = 6,
    parameter int QW     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 msi_valid,
    input  logic [PAYLOAD_W-1:0] msi_data,
    input  logic [QW-1:0]        tgt_q,
    input  logic                 tgt_full,
    input  logic [ADDR_W-1:0]    tgt_base,
    input  logic [PW-1:0]        tgt_tail,
    input  logic                 mem_ack,
    output logic                 msi_ready,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [ENTRY_W-1:0]   mem_wdata,
    output logic                 adv_en,
    output logic [QW-1:0]        adv_q
);

    typedef struct packed {
        wstate_e             state;
        logic [QW-1:0]       q;
        logic [ADDR_W-1:0]   addr;
        logic [ENTRY_W-1:0]  data;
    } wr_st_t;

    wr_st_t st_d, st_q;
    logic   ready_c;

    always_comb begin
        st_d    = st_q;
        ready_c = (st_q.state == WS_IDLE) && !tgt_full;
        adv_en  = 1'b0;
        case (st_q.state)
            WS_IDLE: begin
                if (msi_valid && ready_c) begin
                    st_d.state = WS_BUSY;
                    st_d.q     = tgt_q;
                    st_d.addr  = tgt_base + ADDR_W'({tgt_tail, 2'b00});
                    st_d.data  = {{(ENTRY_W-PAYLOAD_W){1'b0}}, msi_data};
                end
            end
            WS_BUSY: begin
                if (mem_ack) begin
                    st_d.state = WS_IDLE;
                    adv_en     = 1'b1;
                end
            end
            default: st_d.state = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msi_ready = ready_c;
    assign mem_req   = (st_q.state == WS_BUSY);
    assign mem_addr  = st_q.addr;
    assign mem_wdata = st_q.data;
    assign adv_q     = st_q.q;

endmodule

// File: rtl/msi_evq_writer.sv
module msi_evq_writer
    import msi_evq_pkg::*;
#(
    parameter int NUM_Q       = 4,
    parameter int QUEUE_DEPTH = 64,
    parameter int NUM_VEC     = 64,
    parameter int ADDR_W      = 32,
    localparam int QW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int PW    = $clog2(QUEUE_DEPTH),
    localparam int VW    = $clog2(NUM_VEC),
    localparam int IDX_W = (VW > QW) ? VW : QW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 msi_valid,
    output logic                 msi_ready,
    input  logic [VW-1:0]        msi_vec,
    input  logic [PAYLOAD_W-1:0] msi_data,
    input  logic                 reg_we,
    input  logic [1:0]           reg_sel,
    input  logic [IDX_W-1:0]     reg_idx,
    input  logic [ADDR_W-1:0]    reg_wdata,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [ENTRY_W-1:0]   mem_wdata,
    input  logic                 mem_ack,
    output logic [NUM_Q-1:0]     irq
);

    logic [QW-1:0]                tgt_q;
    logic [NUM_Q-1:0][PW-1:0]     tails;
    logic [NUM_Q-1:0][ADDR_W-1:0] bases;
    logic [NUM_Q-1:0]             fulls;
    logic                         adv_en;
    logic [QW-1:0]                adv_q;
    logic                         map_we;

    assign map_we = reg_we && (reg_sel == RSEL_MAP);

    msi_evq_map #(
        .NUM_VEC (NUM_VEC),
        .NUM_Q   (NUM_Q)
    ) map_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (map_we),
        .wr_vec (reg_idx[VW-1:0]),
        .wr_q   (reg_wdata[QW-1:0]),
        .rd_vec (msi_vec),
        .rd_q   (tgt_q)
    );

    msi_evq_qstate #(
        .NUM_Q       (NUM_Q),
        .QUEUE_DEPTH (QUEUE_DEPTH),
        .ADDR_W      (ADDR_W)
    ) qstate_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_idx   (reg_idx[QW-1:0]),
        .reg_wdata (reg_wdata),
        .adv_en    (adv_en),
        .adv_q     (adv_q),
        .tail_o    (tails),
        .base_o    (bases),
        .full_o    (fulls),
        .irq_o     (irq)
    );

    msi_evq_wr #(
        .ADDR_W (ADDR_W),
        .PW     (PW),
        .QW     (QW)
    ) wr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .msi_valid (msi_valid),
        .msi_data  (msi_data),
        .tgt_q     (tgt_q),
        .tgt_full  (fulls[tgt_q]),
        .tgt_base  (bases[tgt_q]),
        .tgt_tail  (tails[tgt_q]),
        .mem_ack   (mem_ack),
        .msi_ready (msi_ready),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .adv_en    (adv_en),
        .adv_q     (adv_q)
    );

endmodule

// File: rtl/msi_evq_writer_chk.sv
module msi_evq_writer_chk #(
    parameter int NUM_Q  = 4,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msi_valid,
    input logic              msi_ready,
    input logic              reg_we,
    input logic [1:0]        reg_sel,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack,
    input logic [NUM_Q-1:0]  irq
);

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)))
        else $error("R5 request dropped or changed before ack");

    p_single_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !msi_ready)
        else $error("R5 accept possible while write outstanding");

    p_accept_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_valid && msi_ready) |=> mem_req)
        else $error("R5 accepted MSI did not raise mem_req");

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_wdata[31:16] == 16'h0))
        else $error("R2 reserved entry bits not zero");

    for (genvar g = 0; g < NUM_Q; g++) begin : g_irq_chk
        p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[g]) |-> $past(mem_req && mem_ack))
            else $error("R7 irq rose without acknowledged write");

        p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[g]) |-> $past(reg_we && (reg_sel == 2'd0)))
            else $error("R7 irq fell without head write");
    end

endmodule

bind msi_evq_writer msi_evq_writer_chk #(
    .NUM_Q  (NUM_Q),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .msi_valid (msi_valid),
    .msi_ready (msi_ready),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .irq       (irq)
);

// File: tb/msi_evq_writer_tb.sv
module msi_evq_writer_tb_top;

    localparam int NQ = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msi_valid = 1'b0;
    logic        msi_ready;
    logic [5:0]  msi_vec = '0;
    logic [15:0] msi_data = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [5:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [NQ-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model
    int m_map[64];
    int m_head[NQ];
    int m_tail[NQ];
    logic [31:0] m_base[NQ];
    bit   pend = 1'b0;
    bit   pend_seen = 1'b0;
    int   p_q;
    logic [31:0] p_addr;
    logic [31:0] p_data;
    bit   accepted;
    logic [31:0] last_addr;
    int   last_q;

    always #4 clk = ~clk;

    msi_evq_writer dut_i (
        .clk(clk), .rst_n(rst_n),
        .msi_valid(msi_valid), .msi_ready(msi_ready),
        .msi_vec(msi_vec), .msi_data(msi_data),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit m_full(input int q);
        return ((m_tail[q] + 1) % 64) == m_head[q];
    endfunction

    function automatic int m_occ(input int q);
        return (m_tail[q] - m_head[q] + 64) % 64;
    endfunction

    // one clock: check outputs, update model for the coming edge, advance
    task automatic cycle();
        bit exp_ready;
        accepted = 1'b0;
        for (int q = 0; q < NQ; q++) begin
            chk(irq[q] == (m_head[q] != m_tail[q]), "R7", "irq level", irq[q],
                m_head[q] != m_tail[q]);
        end
        exp_ready = !pend && !m_full(m_map[msi_vec]);
        chk(msi_ready == exp_ready, "R6", "msi_ready", msi_ready, exp_ready);
        chk(mem_req == pend, "R5", "mem_req", mem_req, pend);
        if (pend && mem_req && !pend_seen) begin
            pend_seen = 1'b1;
            chk(mem_addr == p_addr, "R3", "entry address", mem_addr, p_addr);
            chk(mem_wdata == p_data, "R2", "entry word", mem_wdata, p_data);
        end
        if (pend && mem_ack) begin
            m_tail[p_q] = (m_tail[p_q] + 1) % 64;
            pend = 1'b0;
        end else if (msi_valid && msi_ready) begin
            accepted  = 1'b1;
            pend      = 1'b1;
            pend_seen = 1'b0;
            p_q       = m_map[msi_vec];
            p_addr    = m_base[p_q] + 32'(4 * m_tail[p_q]);
            p_data    = {16'h0, msi_data};
            last_addr = p_addr;
            last_q    = p_q;
        end
        if (reg_we) begin
            case (reg_sel)
                2'd0: if (reg_idx < NQ) m_head[reg_idx] = int'(reg_wdata[5:0]);
                2'd1: if (reg_idx < NQ) m_base[reg_idx] = reg_wdata;
                2'd2: m_map[reg_idx] = int'(reg_wdata[1:0]);
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        mem_ack = pend && (($urandom % 3) != 0);
    endtask

    task automatic reg_write(input int sel, input int idx, input logic [31:0] val);
        reg_we = 1'b1; reg_sel = 2'(sel); reg_idx = 6'(idx); reg_wdata = val;
        cycle();
        reg_we = 1'b0;
    endtask

    // offer an MSI for up to max_wait cycles; returns whether it was taken
    task automatic send_msi(input int vec, input logic [15:0] data, input int max_wait,
                            output bit taken);
        taken = 1'b0;
        msi_valid = 1'b1; msi_vec = 6'(vec); msi_data = data;
        for (int i = 0; i < max_wait && !taken; i++) begin
            cycle();
            taken = accepted;
        end
        msi_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 40 && pend; i++) cycle();
    endtask

    initial begin
        bit ok;
        void'($urandom(32'd20151204));
        for (int v = 0; v < 64; v++) m_map[v] = v % NQ;
        for (int q = 0; q < NQ; q++) begin
            m_head[q] = 0; m_tail[q] = 0; m_base[q] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(irq == '0, "R1", "irq after reset", irq, 0);
        chk(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
        chk(msi_ready == 1'b1, "R1", "msi_ready after reset", msi_ready, 1);

        // R9 distinct base per queue
        for (int q = 0; q < NQ; q++) reg_write(1, q, 32'h1000_0000 + 32'(q) * 32'h1000);

        // R1 reset map: vector 6 lands in queue 2
        send_msi(6, 16'hBEEF, 5, ok);
        chk(ok, "R1", "first msi taken", ok, 1);
        chk(last_q == 2 && last_addr == 32'h1000_2000, "R1", "reset map vec6",
            last_addr, 32'h1000_2000);
        drain();
        cycle();
        chk(irq[2] == 1'b1, "R7", "irq raised after write", irq[2], 1);
        reg_write(0, 2, 32'd1);
        chk(irq[2] == 1'b0, "R7", "irq cleared by head write", irq[2], 0);

        // R9 sel=3 changes nothing: queue 1 base stays
        reg_write(3, 1, 32'hDEAD_0000);
        send_msi(1, 16'h0011, 5, ok);
        chk(last_addr == 32'h1000_1000, "R9", "sel3 no effect", last_addr, 32'h1000_1000);
        drain();

        // R8 remap vector 5 from queue 1 to queue 3
        reg_write(2, 5, 32'd3);
        send_msi(5, 16'h5555, 5, ok);
        chk(last_q == 3 && last_addr == 32'h1000_3000, "R8", "remapped vector",
            last_addr, 32'h1000_3000);
        drain();

        // R8 same-edge map write uses old mapping
        reg_we = 1'b1; reg_sel = 2'd2; reg_idx = 6'd9; reg_wdata = 32'd0;
        msi_valid = 1'b1; msi_vec = 6'd9; msi_data = 16'h0909;
        cycle();
        reg_we = 1'b0; msi_valid = 1'b0;
        chk(accepted && last_q == 1, "R8", "same-edge map uses old", last_q, 1);
        drain();

        // R6 fill queue 0 (head 0) to 63 entries
        for (int i = 0; i < 63; i++) begin
            send_msi(0, 16'(i), 10, ok);
            drain();
        end
        chk(m_tail[0] == 63, "R6", "queue 0 filled", m_tail[0], 63);
        send_msi(4, 16'hFFFF, 8, ok);
        chk(!ok, "R6", "full queue holds MSI", ok, 0);
        chk(mem_req == 1'b0, "R6", "no write while full", mem_req, 0);

        // R6 free slots, R4 wrap from 63 to 0
        reg_write(0, 0, 32'd10);
        send_msi(4, 16'hA063, 5, ok);
        chk(ok && last_addr == 32'h1000_0000 + 32'd252, "R4", "slot 63 address",
            last_addr, 32'h1000_00FC);
        drain();
        send_msi(8, 16'hA000, 5, ok);
        chk(ok && last_addr == 32'h1000_0000, "R4", "wrapped to slot 0",
            last_addr, 32'h1000_0000);
        drain();
        cycle();
        chk(irq[0] == 1'b1, "R7", "irq still high after wrap", irq[0], 1);

        // constrained random phase
        for (int n = 0; n < 1500; n++) begin
            int r = $urandom % 10;
            if (r < 6) begin
                send_msi(int'($urandom % 64), 16'($urandom), 6, ok);
            end else if (r < 8) begin
                int q = int'($urandom % NQ);
                int k = int'($urandom % (m_occ(q) + 1));
                reg_write(0, q, 32'((m_head[q] + k) % 64));
            end else if (r < 9) begin
                reg_write(2, int'($urandom % 64), 32'($urandom % NQ));
            end else begin
                cycle();
            end
        end
        drain();
        cycle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule